// File: doc/BRIEF.md
# Multicycle 16-bit Register-Machine Core

This core is a small processor that runs each instruction as a sequence of controller states. It has no accumulator. It holds eight 16-bit general registers, a program counter, an instruction register, an address register and an operand register. Around them sit an ALU, a shifter and a magnitude comparator.

Instructions and data come from one external memory over a shared bidirectional 16-bit bus. Every access uses the same handshake: the core raises a valid strobe, sets the direction flag, and holds the address until the memory returns ready. One-word instructions carry all their operands in the word. Two-word instructions take an immediate value or a branch target from the word that follows.

The core suits control sequencing where a tiny programmable engine shares a slow memory, and where any number of wait states is normal.

Top module: `mc16_core`

## Requirements
- R1: While reset is held, and for five clock edges after it is released, the core makes no memory access. On the sixth rising edge after release it starts a read of the first instruction at address 0000h.
- R2: The program counter goes up by one for each instruction word fetched, and by one more when an immediate or target word is read. The next fetch therefore comes from the word after the last word used.
- R3: During a memory access the core holds `vma_o` high, with `rw_o` at 1 for a read and 0 for a write. It keeps address and direction steady until it samples `ready_i` high. If `ready_i` is already high in the first cycle of the access, the access completes in that cycle.
- R4: The core drives `data_io` only during a write access, and holds that data steady while it waits. At all other times `data_io` is left at high impedance.
- R5: The instruction word has the opcode in bits 15..11, the source register in bits 5..3 and the destination register in bits 2..0. LOAD (opcode 00001) reads the memory word addressed by the source register into the destination register.
- R6: STORE (opcode 00010) writes the source register to the memory word addressed by the destination register.
- R7: LOADI (opcode 00100) writes the following word into the destination register.
- R8: MOVE (opcode 00011) copies the source register into the destination register.
- R9: INC (opcode 00111) adds one to the destination register, wrapping from FFFFh to 0000h.
- R10: BRANCHI (opcode 00101) always loads the following word into the program counter.
- R11: BRANCHGTI (opcode 00110) loads the following word into the program counter only when the source register is greater than the destination register, compared unsigned. If the two are equal or the source is smaller, execution continues after the target word.
- R12: Any other opcode does nothing except advance the program counter past its single word.
- R13: All eight registers read 0000h after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Memory has completed the current access |
| addr_o | output | 16 | Memory word address |
| rw_o | output | 1 | Access direction: 1 read, 0 write |
| vma_o | output | 1 | A memory access is in progress |
| data_io | inout | 16 | Shared data bus, driven by the core only on writes |

## Verification
Two events can fall in the same cycle: the start of an access and its completion. When the memory returns ready at once, the core must raise the strobe and also capture data or release the bus in that single cycle. One program therefore runs with ready held high. The others add two and three wait states, and a bench monitor flags any change of address or direction before ready arrives. The tests are judged on the memory words the programs store, on the address of the first fetch, and on the cycle in which the immediate read starts.

// File: rtl/mc16_pkg.sv
`timescale 1ns/1ps
package mc16_pkg;
  typedef enum logic [3:0] {
    ALU_PASS = 4'd0, ALU_AND = 4'd1, ALU_OR  = 4'd2, ALU_NOT  = 4'd3, ALU_XOR = 4'd4,
    ALU_ADD  = 4'd5, ALU_SUB = 4'd6, ALU_INC = 4'd7, ALU_DEC  = 4'd8, ALU_ZERO = 4'd9
  } alu_op_e;

  typedef enum logic [2:0] {SH_PASS, SH_SHL, SH_SHR, SH_ROL, SH_ROR} shift_e;

  typedef enum logic [2:0] {CMP_EQ, CMP_NE, CMP_GT, CMP_GE, CMP_LT, CMP_LE} cmp_e;

  typedef enum logic [4:0] {
    OP_NOP = 5'd0, OP_LOAD = 5'd1, OP_STORE = 5'd2, OP_MOVE = 5'd3,
    OP_LOADI = 5'd4, OP_BRA = 5'd5, OP_BGT = 5'd6, OP_INC = 5'd7
  } opcode_e;

  typedef enum logic [2:0] {
    ST_RST, ST_FETCH, ST_DECODE, ST_LD, ST_ST, ST_IMM, ST_EXEC
  } state_e;
endpackage

// File: rtl/mc16_regfile.sv
`timescale 1ns/1ps
module mc16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [DW-1:0] ra_o,
  output logic [DW-1:0] rb_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i
);
  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign ra_o = regs_q[ra_i];
  assign rb_o = regs_q[rb_i];

  p_rf_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/mc16_alu.sv
`timescale 1ns/1ps
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_PASS: y_o = a_i;
      ALU_AND:  y_o = a_i & b_i;
      ALU_OR:   y_o = a_i | b_i;
      ALU_NOT:  y_o = ~a_i;
      ALU_XOR:  y_o = a_i ^ b_i;
      ALU_ADD:  y_o = a_i + b_i;
      ALU_SUB:  y_o = a_i - b_i;
      ALU_INC:  y_o = a_i + 1'b1;
      ALU_DEC:  y_o = a_i - 1'b1;
      ALU_ZERO: y_o = '0;
      default:  y_o = a_i;
    endcase
  end
endmodule

// File: rtl/mc16_shift.sv
`timescale 1ns/1ps
module mc16_shift
  import mc16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  shift_e        mode_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    case (mode_i)
      SH_SHL:  y_o = {a_i[DW-2:0], 1'b0};
      SH_SHR:  y_o = {1'b0, a_i[DW-1:1]};
      SH_ROL:  y_o = {a_i[DW-2:0], a_i[DW-1]};
      SH_ROR:  y_o = {a_i[0], a_i[DW-1:1]};
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/mc16_cmp.sv
`timescale 1ns/1ps
module mc16_cmp
  import mc16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  cmp_e          mode_i,
  output logic          hit_o
);
  always_comb begin
    case (mode_i)
      CMP_EQ:  hit_o = (a_i == b_i);
      CMP_NE:  hit_o = (a_i != b_i);
      CMP_GT:  hit_o = (a_i >  b_i);
      CMP_GE:  hit_o = (a_i >= b_i);
      CMP_LT:  hit_o = (a_i <  b_i);
      CMP_LE:  hit_o = (a_i <= b_i);
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mc16_core.sv
`timescale 1ns/1ps
module mc16_core
  import mc16_pkg::*;
#(
  parameter int DW        = 16,
  parameter int NREG      = 8,
  parameter int RST_STEPS = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_i,
  output logic [DW-1:0] addr_o,
  output logic          rw_o,
  output logic          vma_o,
  inout  wire  [DW-1:0] data_io
);
  localparam int RW  = $clog2(NREG);
  localparam int OPW = 5;
  localparam int CW  = $clog2(RST_STEPS);

  state_e        state_q;
  logic [CW-1:0] rst_cnt_q;
  logic [DW-1:0] pc_q, ir_q, addr_q, op_q;

  opcode_e       opc;
  logic [RW-1:0] src, dst;
  logic          unused_ir;

  assign opc       = opcode_e'(ir_q[DW-1 -: OPW]);
  assign src       = ir_q[RW +: RW];
  assign dst       = ir_q[0 +: RW];
  assign unused_ir = ^ir_q[DW-OPW-1:2*RW];

  logic [DW-1:0] rs_data, rd_data, alu_a, alu_y, sh_y;
  alu_op_e       alu_op;
  logic          gt_hit;
  logic          rf_we;
  logic [DW-1:0] rf_wdata;

  mc16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .ra_i(src), .rb_i(dst), .ra_o(rs_data), .rb_o(rd_data),
    .we_i(rf_we), .waddr_i(dst), .wdata_i(rf_wdata)
  );

  assign alu_op = (opc == OP_INC) ? ALU_INC : ALU_PASS;
  assign alu_a  = (opc == OP_INC) ? rd_data : rs_data;

  mc16_alu #(.DW(DW)) u_alu (.a_i(alu_a), .b_i(rd_data), .op_i(alu_op), .y_o(alu_y));
  mc16_shift #(.DW(DW)) u_sh (.a_i(alu_y), .mode_i(SH_PASS), .y_o(sh_y));
  mc16_cmp #(.DW(DW)) u_cmp (.a_i(rs_data), .b_i(rd_data), .mode_i(CMP_GT), .hit_o(gt_hit));

  // bus side
  always_comb begin
    vma_o  = (state_q == ST_FETCH) || (state_q == ST_LD) ||
             (state_q == ST_ST)    || (state_q == ST_IMM);
    rw_o   = (state_q != ST_ST);
    addr_o = ((state_q == ST_LD) || (state_q == ST_ST)) ? addr_q : pc_q;
  end

  assign data_io = (state_q == ST_ST) ? op_q : 'z;

  // register write-back
  always_comb begin
    rf_we    = 1'b0;
    rf_wdata = sh_y;
    case (state_q)
      ST_LD: begin
        rf_we    = ready_i;
        rf_wdata = data_io;
      end
      ST_DECODE: rf_we = (opc == OP_MOVE) || (opc == OP_INC);
      ST_EXEC: begin
        rf_we    = (opc == OP_LOADI);
        rf_wdata = op_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RST;
      rst_cnt_q <= '0;
      pc_q      <= '0;
      ir_q      <= '0;
      addr_q    <= '0;
      op_q      <= '0;
    end else begin
      case (state_q)
        ST_RST: begin
          pc_q <= '0;
          if (rst_cnt_q == CW'(RST_STEPS - 1)) state_q <= ST_FETCH;
          else rst_cnt_q <= rst_cnt_q + 1'b1;
        end
        ST_FETCH: if (ready_i) begin
          ir_q    <= data_io;
          pc_q    <= pc_q + 1'b1;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          case (opc)
            OP_LOAD: begin
              addr_q  <= rs_data;
              state_q <= ST_LD;
            end
            OP_STORE: begin
              addr_q  <= rd_data;
              op_q    <= rs_data;
              state_q <= ST_ST;
            end
            OP_LOADI, OP_BRA, OP_BGT: state_q <= ST_IMM;
            default: state_q <= ST_FETCH;
          endcase
        end
        ST_LD, ST_ST: if (ready_i) state_q <= ST_FETCH;
        ST_IMM: if (ready_i) begin
          op_q    <= data_io;
          pc_q    <= pc_q + 1'b1;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if ((opc == OP_BRA) || ((opc == OP_BGT) && gt_hit)) pc_q <= op_q;
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_RST;
      endcase
    end
  end

  p_first_fetch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && $past(state_q) == ST_RST) |-> addr_o == '0);

  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && ready_i) |=> pc_q == DW'($past(pc_q) + 1'b1));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vma_o && !ready_i) |=> vma_o && $stable(addr_o) && $stable(rw_o));

  p_wdata_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vma_o && !rw_o && !ready_i) |=> $stable(data_io));
endmodule

// File: tb/mc16_core_test.sv
`timescale 1ns/1ps
module mc16_core_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ready_i;
  logic [15:0] addr_o;
  logic        rw_o, vma_o;
  wire  [15:0] data_io;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int cyc    = 0;
  int hold_viol = 0;
  int z_viol    = 0;

  logic [15:0] mem [256];
  logic [15:0] img [256];
  logic [3:0]  wcnt;

  always #2.5 clk = ~clk;

  mc16_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .ready_i(ready_i),
    .addr_o(addr_o), .rw_o(rw_o), .vma_o(vma_o), .data_io(data_io)
  );

  // memory model
  assign ready_i = vma_o && (int'(wcnt) >= lat);
  assign data_io = (vma_o && rw_o) ? mem[addr_o[7:0]] : 16'hzzzz;

  always @(posedge clk) begin
    if (!rst_ni) begin
      mem  <= img;
      wcnt <= '0;
    end else begin
      if (!vma_o || ready_i) wcnt <= '0;
      else wcnt <= wcnt + 1'b1;
      if (vma_o && !rw_o && ready_i) mem[addr_o[7:0]] <= data_io;
    end
  end

  // protocol monitor
  logic        p_vma = 1'b0, p_rdy = 1'b0, p_rw = 1'b0;
  logic [15:0] p_addr = '0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (p_vma && !p_rdy && (!vma_o || addr_o != p_addr || rw_o != p_rw)) hold_viol++;
      if (!vma_o && data_io !== 16'hzzzz) z_viol++;
    end
    p_vma  <= vma_o && rst_ni;
    p_rdy  <= ready_i;
    p_addr <= addr_o;
    p_rw   <= rw_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 16'h0000;
  endtask

  task automatic start(input int l);
    rst_ni = 1'b0;
    lat = l;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // R1, R2, R3, R4: reset sequence and first two reads with zero wait
  task automatic t_reset();
    logic early;
    clear_img();
    img[0] = 16'h2001; img[1] = 16'h0021; img[2] = 16'h2800; img[3] = 16'h0002;
    rst_ni = 1'b0;
    lat = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 vma in reset", {15'd0, vma_o}, 16'h0000);
    chk("R4 bus released in reset", data_io, 16'hzzzz);
    rst_ni = 1'b1;
    early = 1'b0;
    repeat (5) begin
      @(posedge clk); @(negedge clk);
      if (vma_o) early = 1'b1;
    end
    chk("R1 no access before edge 6", {15'd0, early}, 16'h0000);
    @(posedge clk); @(negedge clk);
    chk("R1 vma at edge 6", {15'd0, vma_o}, 16'h0001);
    chk("R1 first addr", addr_o, 16'h0000);
    chk("R3 read direction", {15'd0, rw_o}, 16'h0001);
    @(posedge clk); @(negedge clk);   // decode
    @(posedge clk); @(negedge clk);   // immediate read
    chk("R2 immediate read addr", addr_o, 16'h0001);
    chk("R3 same-cycle ready", {15'd0, vma_o & ready_i}, 16'h0001);
    @(posedge clk); @(negedge clk);   // exec
    @(posedge clk); @(negedge clk);   // next fetch
    chk("R2 next fetch addr", addr_o, 16'h0002);
  endtask

  // R5 R6 R7 R8 R9 R10 R12 with zero wait
  task automatic t_move_data();
    clear_img();
    img[0]  = 16'h2001; img[1]  = 16'h0040;
    img[2]  = 16'h2002; img[3]  = 16'h0041;
    img[4]  = 16'h080B;                      // LOAD R3,[R1]
    img[5]  = 16'h3803;                      // INC R3
    img[6]  = 16'h101A;                      // STORE [R2],R3
    img[7]  = 16'h181C;                      // MOVE R4,R3
    img[8]  = 16'h3802;                      // INC R2
    img[9]  = 16'h1022;                      // STORE [R2],R4
    img[10] = 16'hF800;                      // undefined
    img[11] = 16'h2800; img[12] = 16'h000B;  // halt loop
    img[16'h40] = 16'h1234;
    img[16'h43] = 16'h5555;
    start(0);
    repeat (150) @(posedge clk);
    @(negedge clk);
    chk("R5 R6 R7 R9 load-inc-store", mem[8'h41], 16'h1235);
    chk("R8 move then store", mem[8'h42], 16'h1235);
    chk("R12 neighbour untouched", mem[8'h43], 16'h5555);
    chk("R10 R12 pc in halt loop", {15'd0, (addr_o >= 16'd11 && addr_o <= 16'd13)}, 16'h0001);
  endtask

  // R11 R13 with two wait states
  task automatic t_branch();
    clear_img();
    img[0]  = 16'h2001; img[1]  = 16'h0005;  // R1=5
    img[2]  = 16'h2006; img[3]  = 16'h0003;  // R6=3
    img[4]  = 16'h300E; img[5]  = 16'h000A;  // 5>3 taken
    img[6]  = 16'h2007; img[7]  = 16'h0BAD;  // skipped
    img[8]  = 16'h2800; img[9]  = 16'h0008;
    img[10] = 16'h3031; img[11] = 16'h0000;  // 3>5 not taken
    img[12] = 16'h2005; img[13] = 16'h00AA;
    img[14] = 16'h2000; img[15] = 16'h0080;
    img[16] = 16'h1028;                      // STORE [R0],R5
    img[17] = 16'h3800;                      // INC R0
    img[18] = 16'h1038;                      // STORE [R0],R7
    img[19] = 16'h2800; img[20] = 16'h0013;
    start(2);
    repeat (400) @(posedge clk);
    @(negedge clk);
    chk("R11 not-taken falls through", mem[8'h80], 16'h00AA);
    chk("R11 R13 taken skips, reg reset", mem[8'h81], 16'h0000);
  endtask

  // R9 R11 with three wait states: wrap and equal compare
  task automatic t_wrap_equal();
    clear_img();
    img[0]  = 16'h2002; img[1]  = 16'hFFFF;
    img[2]  = 16'h3802;                      // INC R2 -> 0000
    img[3]  = 16'h2000; img[4]  = 16'h0090;
    img[5]  = 16'h1010;                      // STORE [R0],R2
    img[6]  = 16'h2003; img[7]  = 16'h0007;
    img[8]  = 16'h2004; img[9]  = 16'h0007;
    img[10] = 16'h301C; img[11] = 16'h000E;  // 7>7 not taken
    img[12] = 16'h3800;                      // INC R0
    img[14] = 16'h1018;                      // STORE [R0],R3
    img[15] = 16'h2800; img[16] = 16'h000F;
    img[16'h90] = 16'h5A5A;
    img[16'h91] = 16'h5A5A;
    start(3);
    repeat (500) @(posedge clk);
    @(negedge clk);
    chk("R9 increment wraps", mem[8'h90], 16'h0000);
    chk("R11 equal not taken", mem[8'h91], 16'h0007);
  endtask

  initial begin
    t_reset();
    t_move_data();
    t_branch();
    t_wrap_equal();
    chk("R3 address held until ready", hold_viol[15:0], 16'h0000);
    chk("R4 bus idle when no access", z_viol[15:0], 16'h0000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule